// File: doc/BRIEF.md
# Cyclic Descriptor-Ring Stream DMA

This block walks a linked list of buffer descriptors held in memory and sends the words of each referenced buffer, in address order, out of a stream master with VALID/READY/LAST handshaking. Software programs the address of the first descriptor and a tail descriptor address, then sets the run bit in the control register. Each descriptor occupies one wide memory word that holds the next-descriptor address, the buffer base address and the buffer length in words.

In single-pass operation the engine stops after the tail descriptor, reports idle and can raise a completion interrupt. With the cyclic bit set, the tail is ignored. The chain is expected to close on itself, and the engine replays the ring until software clears the run bit. The next descriptor is prefetched while the current buffer is still being read, so buffer and ring boundaries add no idle cycles to the stream.

The block has two memory read lanes: one for descriptors and one for data words. Both take a request in one cycle and return the word in the next cycle.

Top module: `ring_stream_dma`

## Requirements
- R1: After reset the status register (offset 1) reads 0x1 (only halted, bit 0), and m_tvalid, irq, dsc_req and dat_req are all low.
- R2: A write to the control register (offset 0) with bit 0 set, while the engine is stopped, fetches the descriptor at the current pointer (offset 2). A descriptor word is {next[47:32], base[31:16], words[15:0]}. Words base .. base+words-1 appear on m_tdata in that order, and then the chain is followed through next.
- R3: m_tlast is high on the final word of every descriptor's buffer and low on all other words.
- R4: While m_tvalid is high and m_tready is low, m_tdata and m_tlast hold their values and m_tvalid stays high.
- R5: With control bit 4 clear, the engine stops after the descriptor whose address equals the tail pointer (offset 3). Status idle (bit 1) and done (bit 12) then read 1, and halted (bit 0) reads 0.
- R6: With control bit 4 set, the tail pointer is ignored, the ring is followed indefinitely, and status idle never reads 1.
- R7: With m_tready held high and every buffer at least 2 words long, m_tvalid has no low cycle between the first word and the stop, including at buffer and ring wrap boundaries.
- R8: irq equals status done (bit 12) AND control bit 12. Writing the status register with bit 12 set clears done.
- R9: Writing the control register with bit 0 clear stops the engine at a descriptor boundary. The stream ends on a word with m_tlast, and once the stream is empty status halted (bit 0) reads 1.
- R10: A descriptor with words = 0 sets status error (bit 2), streams nothing from that descriptor, and leads to halted.
- R11: The current pointer (offset 2) is writable only while the engine is stopped. While running it tracks the address of the descriptor being read, so after a single pass it reads the tail address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write offset (0 ctrl, 1 status, 2 current, 3 tail) |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 2 | Register read offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| dsc_req | output | 1 | Descriptor read request |
| dsc_addr | output | 16 | Descriptor word address |
| dsc_rdata | input | 48 | Descriptor word, valid the cycle after the request |
| dat_req | output | 1 | Data read request |
| dat_addr | output | 16 | Data word address |
| dat_rdata | input | 32 | Data word, valid the cycle after the request |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready |
| m_tdata | output | 32 | Stream data |
| m_tlast | output | 1 | Last word of a descriptor's buffer |
| irq | output | 1 | Completion interrupt |

## Verification
Two events can fall in the same cycle. The issue of the last data read of one buffer can coincide with the arrival of the next descriptor from memory, and this includes the wrap from the final ring entry back to the first. The bench provokes this with a ring containing a 2-word buffer, run cyclically with READY held high. It then counts every cycle in which READY is high but VALID is low; that count must be zero. The replayed words are compared against a walk of the ring computed in the bench, and each must also end on LAST. A second pairing has the stop command landing while a prefetched descriptor is waiting. This is judged by requiring that the stream ends exactly on a buffer boundary of the ring walk.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    localparam int PTR_W  = 16;
    localparam int LEN_W  = 16;
    localparam int DESC_W = 2 * PTR_W + LEN_W;

    typedef struct packed {
        logic [PTR_W-1:0] next;
        logic [PTR_W-1:0] base;
        logic [LEN_W-1:0] words;
    } desc_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_CUR  = 2'd2,
        REG_TAIL = 2'd3
    } reg_sel_e;

    localparam int CTL_RUN  = 0;
    localparam int CTL_CYC  = 4;
    localparam int CTL_IRQ  = 12;
    localparam int STS_HALT = 0;
    localparam int STS_IDLE = 1;
    localparam int STS_DERR = 2;
    localparam int STS_DONE = 12;

    function automatic logic desc_usable(input desc_t d);
        return d.words != '0;
    endfunction

endpackage

// File: rtl/rsd_desc_prefetch.sv
module rsd_desc_prefetch
    import rsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [PTR_W-1:0]  launch_addr,
    input  logic              fetch_en,
    input  logic              cyclic,
    input  logic [PTR_W-1:0]  tail_addr,
    input  logic              take,
    output logic              dsc_req,
    output logic [PTR_W-1:0]  dsc_addr,
    input  logic [DESC_W-1:0] dsc_rdata,
    output logic              slot_valid,
    output desc_t             slot_desc,
    output logic [PTR_W-1:0]  slot_addr,
    output logic              bad_desc,
    output logic              busy,
    output logic              chain_end
);

    logic             resp_v;
    logic [PTR_W-1:0] req_addr_q;
    logic [PTR_W-1:0] fetch_addr;
    logic             held_v;
    desc_t            held;
    logic [PTR_W-1:0] held_addr;
    desc_t            resp_d;
    logic             resp_good;

    assign resp_d    = desc_t'(dsc_rdata);
    assign resp_good = resp_v && !flush && fetch_en && desc_usable(resp_d);
    assign bad_desc  = resp_v && !flush && fetch_en && !desc_usable(resp_d);

    // The response can be used in the cycle it arrives, so a 2-word buffer is enough to hide it.
    assign slot_valid = held_v || resp_good;
    assign slot_desc  = held_v ? held : resp_d;
    assign slot_addr  = held_v ? held_addr : req_addr_q;

    assign dsc_req  = fetch_en && !flush && !held_v && !resp_v && !chain_end;
    assign dsc_addr = fetch_addr;
    assign busy     = resp_v;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            resp_v     <= 1'b0;
            held_v     <= 1'b0;
            chain_end  <= 1'b0;
            fetch_addr <= launch_addr;
            req_addr_q <= launch_addr;
        end else begin
            resp_v <= dsc_req;
            if (dsc_req)
                req_addr_q <= fetch_addr;
            if (bad_desc)
                chain_end <= 1'b1;
            if (resp_good) begin
                fetch_addr <= resp_d.next;
                if (!cyclic && req_addr_q == tail_addr)
                    chain_end <= 1'b1;
            end
            if (resp_good && !take) begin
                held      <= resp_d;
                held_addr <= req_addr_q;
                held_v    <= 1'b1;
            end else if (take) begin
                held_v <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rsd_word_mover.sv
module rsd_word_mover
    import rsd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_ok,
    input  logic              slot_valid,
    input  desc_t             slot_desc,
    output logic              take,
    output logic              drained,
    output logic              dat_req,
    output logic [PTR_W-1:0]  dat_addr,
    input  logic [DATA_W-1:0] dat_rdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast
);

    localparam int PW = $clog2(FIFO_DEPTH);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic              last;
        logic [DATA_W-1:0] data;
    } beat_t;

    logic             cur_active;
    logic [PTR_W-1:0] cur_ptr;
    logic [LEN_W-1:0] cur_left;
    logic             inflight_v;
    logic             inflight_last;
    beat_t            store [FIFO_DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    fifo_cnt;
    logic [CW:0]      occupancy;
    logic             issue;
    logic             last_issue;
    logic             push;
    logic             pop;
    logic             unused_next;

    assign unused_next = ^slot_desc.next;

    // Reads are only issued while the FIFO can absorb them, which makes backpressure lossless.
    assign occupancy  = {1'b0, fifo_cnt} + {{CW{1'b0}}, inflight_v};
    assign issue      = cur_active && (occupancy < (CW+1)'(FIFO_DEPTH));
    assign last_issue = issue && (cur_left == LEN_W'(1));
    assign take       = load_ok && slot_valid && (!cur_active || last_issue);

    assign dat_req  = issue;
    assign dat_addr = cur_ptr;

    assign push     = inflight_v;
    assign pop      = m_tvalid && m_tready;
    assign m_tvalid = fifo_cnt != '0;
    assign m_tdata  = store[rd_ptr].data;
    assign m_tlast  = store[rd_ptr].last;
    assign drained  = !cur_active && !inflight_v && (fifo_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_active    <= 1'b0;
            cur_ptr       <= '0;
            cur_left      <= '0;
            inflight_v    <= 1'b0;
            inflight_last <= 1'b0;
        end else begin
            inflight_v    <= issue;
            inflight_last <= last_issue;
            if (take) begin
                cur_active <= 1'b1;
                cur_ptr    <= slot_desc.base;
                cur_left   <= slot_desc.words;
            end else if (issue) begin
                cur_ptr  <= cur_ptr + PTR_W'(1);
                cur_left <= cur_left - LEN_W'(1);
                if (last_issue)
                    cur_active <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push)
            store[wr_ptr] <= '{last: inflight_last, data: dat_rdata};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fifo_cnt <= '0;
        end else begin
            if (push)
                wr_ptr <= wr_ptr + PW'(1);
            if (pop)
                rd_ptr <= rd_ptr + PW'(1);
            case ({push, pop})
                2'b10:   fifo_cnt <= fifo_cnt + CW'(1);
                2'b01:   fifo_cnt <= fifo_cnt - CW'(1);
                default: fifo_cnt <= fifo_cnt;
            endcase
        end
    end

    assert_hold_while_stalled_R4: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        push |-> ((fifo_cnt < CW'(FIFO_DEPTH)) || pop));

endmodule

// File: rtl/ring_stream_dma.sv
module ring_stream_dma
    import rsd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int REG_W      = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_addr,
    input  logic [REG_W-1:0]  reg_wr_data,
    input  logic [1:0]        reg_rd_addr,
    output logic [REG_W-1:0]  reg_rd_data,
    output logic              dsc_req,
    output logic [PTR_W-1:0]  dsc_addr,
    input  logic [DESC_W-1:0] dsc_rdata,
    output logic              dat_req,
    output logic [PTR_W-1:0]  dat_addr,
    input  logic [DATA_W-1:0] dat_rdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic              irq
);

    logic             ctrl_run, ctrl_cyc, ctrl_irq;
    logic [PTR_W-1:0] cur_q, tail_q;
    logic             engine_on, stop_q;
    logic             st_halt, st_idle, st_err, st_done;

    logic             wr_ctrl, wr_stat, wr_cur, wr_tail;
    logic             start, stop_cmd, stop_done, chain_done;
    logic             fetch_en;
    logic             slot_valid, take, drained, bad_desc, fetch_busy, chain_end;
    desc_t            slot_desc;
    logic [PTR_W-1:0] slot_addr;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^reg_wr_data;

    assign wr_ctrl = reg_wr_en && (reg_wr_addr == REG_CTRL);
    assign wr_stat = reg_wr_en && (reg_wr_addr == REG_STAT);
    assign wr_cur  = reg_wr_en && (reg_wr_addr == REG_CUR);
    assign wr_tail = reg_wr_en && (reg_wr_addr == REG_TAIL);

    assign start      = wr_ctrl && reg_wr_data[CTL_RUN] && !engine_on;
    assign stop_cmd   = wr_ctrl && !reg_wr_data[CTL_RUN] && engine_on;
    assign fetch_en   = engine_on && !stop_q;
    assign stop_done  = engine_on && stop_q && drained;
    assign chain_done = engine_on && !stop_q && chain_end && drained && !slot_valid && !fetch_busy;

    rsd_desc_prefetch u_prefetch (
        .clk         (clk),
        .rst         (rst),
        .flush       (start),
        .launch_addr (cur_q),
        .fetch_en    (fetch_en),
        .cyclic      (ctrl_cyc),
        .tail_addr   (tail_q),
        .take        (take),
        .dsc_req     (dsc_req),
        .dsc_addr    (dsc_addr),
        .dsc_rdata   (dsc_rdata),
        .slot_valid  (slot_valid),
        .slot_desc   (slot_desc),
        .slot_addr   (slot_addr),
        .bad_desc    (bad_desc),
        .busy        (fetch_busy),
        .chain_end   (chain_end)
    );

    rsd_word_mover #(
        .DATA_W     (DATA_W),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) u_mover (
        .clk        (clk),
        .rst        (rst),
        .load_ok    (fetch_en),
        .slot_valid (slot_valid),
        .slot_desc  (slot_desc),
        .take       (take),
        .drained    (drained),
        .dat_req    (dat_req),
        .dat_addr   (dat_addr),
        .dat_rdata  (dat_rdata),
        .m_tvalid   (m_tvalid),
        .m_tready   (m_tready),
        .m_tdata    (m_tdata),
        .m_tlast    (m_tlast)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_run  <= 1'b0;
            ctrl_cyc  <= 1'b0;
            ctrl_irq  <= 1'b0;
            cur_q     <= '0;
            tail_q    <= '0;
            engine_on <= 1'b0;
            stop_q    <= 1'b0;
            st_halt   <= 1'b1;
            st_idle   <= 1'b0;
            st_err    <= 1'b0;
            st_done   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_run <= reg_wr_data[CTL_RUN];
                ctrl_cyc <= reg_wr_data[CTL_CYC];
                ctrl_irq <= reg_wr_data[CTL_IRQ];
            end
            if (wr_cur && !engine_on)
                cur_q <= reg_wr_data[PTR_W-1:0];
            if (wr_tail)
                tail_q <= reg_wr_data[PTR_W-1:0];
            if (take)
                cur_q <= slot_addr;
            if (wr_stat && reg_wr_data[STS_DONE])
                st_done <= 1'b0;
            if (start) begin
                engine_on <= 1'b1;
                stop_q    <= 1'b0;
                st_halt   <= 1'b0;
                st_idle   <= 1'b0;
                st_err    <= 1'b0;
            end else begin
                if (stop_cmd || bad_desc)
                    stop_q <= 1'b1;
                if (bad_desc)
                    st_err <= 1'b1;
                if (stop_done) begin
                    engine_on <= 1'b0;
                    stop_q    <= 1'b0;
                    st_halt   <= 1'b1;
                end else if (chain_done) begin
                    engine_on <= 1'b0;
                    st_idle   <= 1'b1;
                    st_done   <= 1'b1;
                end
            end
        end
    end

    assign irq = st_done && ctrl_irq;

    always_comb begin
        reg_rd_data = '0;
        case (reg_sel_e'(reg_rd_addr))
            REG_CTRL: begin
                reg_rd_data[CTL_RUN] = ctrl_run;
                reg_rd_data[CTL_CYC] = ctrl_cyc;
                reg_rd_data[CTL_IRQ] = ctrl_irq;
            end
            REG_STAT: begin
                reg_rd_data[STS_HALT] = st_halt;
                reg_rd_data[STS_IDLE] = st_idle;
                reg_rd_data[STS_DERR] = st_err;
                reg_rd_data[STS_DONE] = st_done;
            end
            REG_CUR:  reg_rd_data = REG_W'(cur_q);
            default:  reg_rd_data = REG_W'(tail_q);
        endcase
    end

    assert_cyclic_never_idle_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(st_idle) |-> !$past(ctrl_cyc));

    assert_halt_when_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(st_halt) |-> !m_tvalid);

    assert_bad_desc_flags_R10: assert property (@(posedge clk) disable iff (rst)
        bad_desc |=> st_err);

endmodule

// File: tb/test_ring_stream_dma.sv
`timescale 1ns/1ps
module test_ring_stream_dma;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        dsc_req;
    logic [15:0] dsc_addr;
    logic [47:0] dsc_rdata = '0;
    logic        dat_req;
    logic [15:0] dat_addr;
    logic [31:0] dat_rdata = '0;
    logic        m_tvalid;
    logic        m_tready = 1'b1;
    logic [31:0] m_tdata;
    logic        m_tlast;
    logic        irq;

    logic [47:0] dmem [64];

    int checks = 0, errs = 0;
    int mon_checks = 0, mon_errs = 0;
    int got_n = 0;
    logic [31:0] got_data [512];
    logic        got_last [512];
    logic        gap_watch = 1'b0, cyc_watch = 1'b0;
    int gap_cnt = 0, idle_seen = 0;
    logic        prev_stall = 1'b0, prev_last = 1'b0;
    logic [31:0] prev_data = '0;

    always #4 clk = ~clk;

    ring_stream_dma i_ring_stream_dma (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_rdata(dsc_rdata),
        .dat_req(dat_req), .dat_addr(dat_addr), .dat_rdata(dat_rdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
        .irq(irq)
    );

    // memory model: one-cycle read latency on both lanes
    always @(posedge clk) begin
        if (dsc_req) dsc_rdata <= dmem[dsc_addr[5:0]];
        if (dat_req) dat_rdata <= {16'hA5A5, dat_addr};
    end

    // stream monitor, sampling 1 ns before the rising edge
    always begin
        @(negedge clk); #3;
        if (prev_stall) begin
            mon_checks++;
            if (!(m_tvalid && m_tdata == prev_data && m_tlast == prev_last)) begin
                mon_errs++;
                $display("FAIL R4 stall hold: got v=%0b d=%h l=%0b expected v=1 d=%h l=%0b",
                         m_tvalid, m_tdata, m_tlast, prev_data, prev_last);
            end
        end
        if (m_tvalid && m_tready) begin
            got_data[got_n] = m_tdata;
            got_last[got_n] = m_tlast;
            got_n++;
        end
        prev_stall = m_tvalid && !m_tready;
        prev_data  = m_tdata;
        prev_last  = m_tlast;
        if (gap_watch && m_tready && !m_tvalid) gap_cnt++;
        if (cyc_watch && reg_rd_data[1]) idle_seen++;
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_addr = a;
        #1 d = reg_rd_data;
    endtask

    task automatic wait_status(input logic [31:0] mask, input int limit);
        logic [31:0] s;
        for (int k = 0; k < limit; k++) begin
            rd_reg(2'd1, s);
            if ((s & mask) != 0) break;
        end
    endtask

    // compare n captured beats with a walk of the descriptor chain from 'first'
    task automatic check_stream(input int base, input int n, input logic [15:0] first, input string tag);
        logic [15:0] d;
        int k;
        d = first; k = 0;
        while (k < n) begin
            logic [47:0] w;
            w = dmem[d[5:0]];
            for (int j = 0; j < int'(w[15:0]) && k < n; j++) begin
                logic [31:0] e;
                logic        el;
                e  = {16'hA5A5, w[31:16] + 16'(j)};
                el = (j == int'(w[15:0]) - 1);
                chk(got_data[base+k] == e, {tag, " data (R2)"}, 64'(got_data[base+k]), 64'(e));
                chk(got_last[base+k] == el, {tag, " last (R3)"}, 64'(got_last[base+k]), 64'(el));
                k++;
            end
            d = w[47:32];
        end
    endtask

    function automatic logic on_boundary(input int n);
        int r;
        r = n % 10;
        return (r == 0) || (r == 3) || (r == 5);
    endfunction

    initial begin
        logic [31:0] s;
        int base, at_stop, gap0, fin;
        for (int i = 0; i < 64; i++) dmem[i] = '0;
        dmem[4]  = {16'd9,  16'h0100, 16'd3};
        dmem[9]  = {16'd20, 16'h0200, 16'd2};
        dmem[20] = {16'd4,  16'h0300, 16'd5};
        dmem[30] = {16'd4,  16'h0400, 16'd0};
        dmem[40] = {16'd30, 16'h0500, 16'd2};

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(2'd1, s);
        chk(s == 32'h1, "R1 status after reset", 64'(s), 64'h1);
        chk(!m_tvalid && !irq && !dsc_req && !dat_req, "R1 outputs idle",
            64'({m_tvalid, irq, dsc_req, dat_req}), 64'h0);

        // R11 pointer write while stopped
        wr_reg(2'd2, 32'd4);
        rd_reg(2'd2, s);
        chk(s == 32'd4, "R11 current pointer write", 64'(s), 64'd4);

        // Test A: single pass over the full chain, interrupt enabled
        wr_reg(2'd3, 32'd20);
        base = got_n;
        wr_reg(2'd0, 32'h1001);
        wait_status(32'h2, 400);
        chk(got_n - base == 10, "R5 single pass beat count", 64'(got_n - base), 64'd10);
        check_stream(base, 10, 16'd4, "R2 pass A");
        rd_reg(2'd1, s);
        chk(s == 32'h1002, "R5 status idle+done", 64'(s), 64'h1002);
        chk(irq == 1'b1, "R8 irq raised", 64'(irq), 64'h1);
        rd_reg(2'd2, s);
        chk(s == 32'd20, "R11 current pointer at tail", 64'(s), 64'd20);
        wr_reg(2'd1, 32'h1000);
        #1;
        chk(irq == 1'b0, "R8 irq cleared", 64'(irq), 64'h0);
        rd_reg(2'd1, s);
        chk(s[12] == 1'b0, "R8 done cleared", 64'(s[12]), 64'h0);

        // Test B: stop at an inner tail with READY toggling, interrupt disabled
        wr_reg(2'd2, 32'd4);
        wr_reg(2'd3, 32'd9);
        base = got_n;
        wr_reg(2'd0, 32'h1);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            m_tready = (k % 3) != 2;
            reg_rd_addr = 2'd1;
            #1;
            if (reg_rd_data[1]) break;
        end
        @(negedge clk);
        m_tready = 1'b1;
        chk(got_n - base == 5, "R5 inner tail beat count", 64'(got_n - base), 64'd5);
        check_stream(base, 5, 16'd4, "R4 pass B");
        rd_reg(2'd1, s);
        chk(s == 32'h1002, "R5 status after inner tail", 64'(s), 64'h1002);
        chk(irq == 1'b0, "R8 irq masked", 64'(irq), 64'h0);
        wr_reg(2'd1, 32'h1000);

        // Test C: cyclic replay, tail ignored, gapless, then stop
        wr_reg(2'd2, 32'd4);
        wr_reg(2'd3, 32'd4);
        base = got_n;
        wr_reg(2'd0, 32'h11);
        for (int k = 0; k < 100 && got_n == base; k++) @(negedge clk);
        reg_rd_addr = 2'd1;
        gap0 = gap_cnt;
        gap_watch = 1'b1;
        cyc_watch = 1'b1;
        for (int k = 0; k < 400 && (got_n - base) < 25; k++) @(negedge clk);
        gap_watch = 1'b0;
        at_stop = got_n - base;
        wr_reg(2'd0, 32'h10);
        wait_status(32'h1, 400);
        cyc_watch = 1'b0;
        fin = got_n - base;
        chk(gap_cnt == gap0, "R7 no idle cycles in cyclic run", 64'(gap_cnt - gap0), 64'h0);
        chk(idle_seen == 0, "R6 idle never set in cyclic mode", 64'(idle_seen), 64'h0);
        chk(fin >= 25 && fin >= at_stop, "R6 ran past tail", 64'(fin), 64'd25);
        check_stream(base, fin, 16'd4, "R6 cyclic");
        chk(on_boundary(fin) && got_last[base+fin-1], "R9 stop on boundary", 64'(fin), 64'(at_stop));
        chk(fin - at_stop <= 16, "R9 stop within two buffers", 64'(fin - at_stop), 64'd16);
        rd_reg(2'd1, s);
        chk(s == 32'h1, "R9 halted after stop", 64'(s), 64'h1);
        repeat (20) @(negedge clk);
        chk(got_n - base == fin, "R9 no words after halt", 64'(got_n - base), 64'(fin));

        // Test D: zero-length descriptor in a chain
        wr_reg(2'd2, 32'd40);
        wr_reg(2'd3, 32'd0);
        base = got_n;
        wr_reg(2'd0, 32'h1);
        wait_status(32'h1, 400);
        repeat (5) @(negedge clk);
        chk(got_n - base == 2, "R10 only words before bad descriptor", 64'(got_n - base), 64'd2);
        chk(got_data[base] == 32'hA5A50500 && got_data[base+1] == 32'hA5A50501 && got_last[base+1],
            "R10 words of good descriptor", 64'(got_data[base+1]), 64'hA5A50501);
        rd_reg(2'd1, s);
        chk(s == 32'h5, "R10 error and halted", 64'(s), 64'h5);

        // Test E: zero-length descriptor first
        wr_reg(2'd2, 32'd30);
        base = got_n;
        wr_reg(2'd0, 32'h1);
        wait_status(32'h1, 100);
        repeat (5) @(negedge clk);
        chk(got_n == base, "R10 nothing streamed", 64'(got_n - base), 64'h0);
        rd_reg(2'd1, s);
        chk(s == 32'h5, "R10 error on first descriptor", 64'(s), 64'h5);

        checks += mon_checks;
        errs   += mon_errs;
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks + 1, errs + mon_errs + 1);
        $finish;
    end

endmodule